// File: doc/BRIEF.md
# BT.656 Line Capture and Word Packer

This block sits behind an 8-bit digital video input. On every edge of the pixel clock it accepts one byte. No valid strobe comes with the byte. It searches the stream for embedded timing reference codes. A code is the three-byte preamble 0xFF, 0x00, 0x00 followed by a status byte. The status byte says whether the code opens or closes the active part of a line. It also carries the field and vertical-blanking flags.

Between a start code and an end code the block treats the 4:2:2 luma/chroma bytes as pixel data. It gathers them four at a time into 32-bit words and pushes each finished word into a 16-entry synchronous FIFO. A downstream reader drains the FIFO through a valid/enable pair. A mode input lets lines inside vertical blanking be captured as well.

The block also reports the current field and blanking flags and gives a pulse at each line end. A sticky flag records any word that was lost because the FIFO was full.

Top module: `vcap_top`

## Requirements
- R1: After a synchronous active-high reset, rd_valid_o, field_o, vblank_o, eol_o and ovf_o are all 0, and the parser waits for a fresh preamble.
- R2: The bytes 0xFF, 0x00, 0x00 followed by a status byte form a timing code. In the status byte, bit 4 is H (1 = end code, 0 = start code), bit 5 is V and bit 6 is F. One cycle after the status byte is sampled, field_o shows F and vblank_o shows V.
- R3: A start code with V = 0 opens capture. The first captured byte is the byte after the status byte. Preamble and status bytes are never stored as pixel data.
- R4: Captured bytes fill a word in arrival order (Cb, Y0, Cr, Y1). Byte 0 goes to bits [7:0], byte 1 to [15:8], byte 2 to [23:16] and byte 3 to [31:24]. The fourth byte of a word is sampled at edge k. The word shows on rd_data_o, with rd_valid_o high, after edge k+3 and not earlier.
- R5: An end code closes capture. A partly filled word at that point is dropped. Bytes outside the capture window are never stored.
- R6: eol_o is high for exactly one cycle: the cycle after each end-code status byte.
- R7: A start code with V = 1 opens capture only when vbi_en_i is 1. When vbi_en_i is 0, that line stores nothing.
- R8: The FIFO holds up to 16 words. rd_en_i while rd_valid_o is high removes the head word. Words leave in the order they were written.
- R9: A finished word that meets a full FIFO is discarded, even if a read happens in the same cycle. ovf_o then becomes 1 and stays 1 until a cycle with ovf_clr_i high. If a new overflow and a clear come in the same cycle, the overflow wins.
- R10: Every timing code sends the byte-lane position back to lane 0, so the first word of each line starts with Cb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_i | input | 8 | Video byte stream, one byte per clock |
| vbi_en_i | input | 1 | Also capture lines flagged as vertical blanking |
| rd_en_i | input | 1 | Pop the head word of the FIFO |
| ovf_clr_i | input | 1 | Clear the sticky overflow flag |
| rd_data_o | output | 32 | Head word of the FIFO |
| rd_valid_o | output | 1 | FIFO holds at least one word |
| field_o | output | 1 | F bit of the latest timing code |
| vblank_o | output | 1 | V bit of the latest timing code |
| eol_o | output | 1 | One-cycle pulse after each end code |
| ovf_o | output | 1 | Sticky flag: a word was lost to a full FIFO |

## Verification
The checks assume the source never sends 0xFF, 0x00, 0x00 anywhere except as a timing preamble. They also assume that every active line sits between one start code and one end code, with at least one byte between lines. The stimulus meets these assumptions by drawing pixel values from 16 to 215 and blanking bytes from 0x10 and 0x80. It also sets the protection nibble of each status byte correctly. Line lengths sweep from 0 to 13 bytes, so every word alignment at the end code is covered. Each line is tried with both values of F, V and the blanking-capture mode. One long line is sent with no reads, to fill the FIFO and overflow it.

// File: rtl/vcap_pkg.sv
`timescale 1ns/1ps
package vcap_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] PRE_ONES  = 8'hFF;
    localparam logic [BYTE_W-1:0] PRE_ZEROS = 8'h00;
    localparam int H_BIT = 4;
    localparam int V_BIT = 5;
    localparam int F_BIT = 6;

    typedef struct packed {
        logic [2:0][BYTE_W-1:0] hist;  // [0] newest
        logic [2:0]             tag;   // byte belongs to capture window
        logic                   cap;
        logic                   fld;
        logic                   vbl;
        logic                   eol;
    } dec_state_t;
endpackage

// File: rtl/vcap_timing_decoder.sv
`timescale 1ns/1ps
module vcap_timing_decoder
    import vcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              vbi_en_i,
    output logic              pix_valid_o,
    output logic [BYTE_W-1:0] pix_byte_o,
    output logic              code_hit_o,
    output logic              field_o,
    output logic              vblank_o,
    output logic              eol_o
);
    dec_state_t s_d, s_q;
    logic code_hit, is_end, opens;

    assign code_hit = (s_q.hist[2] == PRE_ONES) && (s_q.hist[1] == PRE_ZEROS)
                   && (s_q.hist[0] == PRE_ZEROS);
    assign is_end   = byte_i[H_BIT];
    assign opens    = !is_end && (!byte_i[V_BIT] || vbi_en_i);

    always_comb begin
        s_d      = s_q;
        s_d.hist = {s_q.hist[1:0], byte_i};
        s_d.tag  = {s_q.tag[1:0], s_q.cap & ~code_hit};
        s_d.eol  = 1'b0;
        if (code_hit) begin
            s_d.tag = '0;          // the held bytes are preamble, never pixels
            s_d.fld = byte_i[F_BIT];
            s_d.vbl = byte_i[V_BIT];
            s_d.cap = opens;
            s_d.eol = is_end;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign pix_valid_o = s_q.tag[2] && !code_hit;
    assign pix_byte_o  = s_q.hist[2];
    assign code_hit_o  = code_hit;
    assign field_o     = s_q.fld;
    assign vblank_o    = s_q.vbl;
    assign eol_o       = s_q.eol;

    AST_EOL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        s_q.eol |=> !s_q.eol);                                   // R6
    AST_END_CLOSES: assert property (@(posedge clk) disable iff (rst)
        code_hit && is_end |=> !s_q.cap);                        // R5
    AST_CODE_NOT_PIXEL: assert property (@(posedge clk) disable iff (rst)
        code_hit |=> !pix_valid_o);                              // R3
endmodule

// File: rtl/vcap_word_packer.sv
`timescale 1ns/1ps
module vcap_word_packer #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      pix_valid_i,
    input  logic [BYTE_W-1:0]         pix_byte_i,
    input  logic                      restart_i,
    output logic                      push_o,
    output logic [LANES*BYTE_W-1:0]   word_o
);
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int WORD_W = LANES * BYTE_W;
    localparam logic [LANE_W-1:0] LAST = LANE_W'(LANES - 1);

    typedef struct packed {
        logic [LANE_W-1:0] lane;
        logic [WORD_W-1:0] acc;
    } pk_state_t;

    pk_state_t s_d, s_q;
    logic [WORD_W-1:0] merged;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign merged[l*BYTE_W +: BYTE_W] =
            (s_q.lane == LANE_W'(l)) ? pix_byte_i : s_q.acc[l*BYTE_W +: BYTE_W];
    end

    always_comb begin
        s_d = s_q;
        if (restart_i) begin
            s_d.lane = '0;
        end else if (pix_valid_i) begin
            s_d.acc  = merged;
            s_d.lane = (s_q.lane == LAST) ? '0 : s_q.lane + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign push_o = pix_valid_i && !restart_i && (s_q.lane == LAST);
    assign word_o = merged;

    AST_LANE_RESTART: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> s_q.lane == '0);                           // R10
endmodule

// File: rtl/vcap_word_fifo.sv
`timescale 1ns/1ps
module vcap_word_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] data_o,
    output logic             valid_o,
    input  logic             ovf_clr_i,
    output logic             ovf_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W:0] FULL_CNT = (PTR_W+1)'(DEPTH);

    typedef struct packed {
        logic [PTR_W:0] wptr;
        logic [PTR_W:0] rptr;
        logic           ovf;
    } ff_state_t;

    ff_state_t s_d, s_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W:0] count;
    logic full, empty, do_wr, do_rd;

    assign count = s_q.wptr - s_q.rptr;
    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);
    assign do_wr = push_i && !full;
    assign do_rd = pop_i && !empty;

    always_comb begin
        s_d = s_q;
        if (do_wr) s_d.wptr = s_q.wptr + 1'b1;
        if (do_rd) s_d.rptr = s_q.rptr + 1'b1;
        s_d.ovf = (s_q.ovf && !ovf_clr_i) || (push_i && full);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[s_q.wptr[PTR_W-1:0]] <= data_i;
    end

    assign data_o  = mem[s_q.rptr[PTR_W-1:0]];
    assign valid_o = !empty;
    assign ovf_o   = s_q.ovf;

    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
        push_i && full |=> (count + (PTR_W+1)'($past(do_rd))) == $past(count)); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        s_q.ovf && !ovf_clr_i |=> s_q.ovf);                      // R9
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);                                      // R8
endmodule

// File: rtl/vcap_top.sv
`timescale 1ns/1ps
module vcap_top #(
    parameter int LANES      = 4,
    parameter int FIFO_DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [vcap_pkg::BYTE_W-1:0]    vid_i,
    input  logic                           vbi_en_i,
    input  logic                           rd_en_i,
    input  logic                           ovf_clr_i,
    output logic [LANES*vcap_pkg::BYTE_W-1:0] rd_data_o,
    output logic                           rd_valid_o,
    output logic                           field_o,
    output logic                           vblank_o,
    output logic                           eol_o,
    output logic                           ovf_o
);
    localparam int BW     = vcap_pkg::BYTE_W;
    localparam int WORD_W = LANES * BW;

    logic          pix_valid, code_hit, push;
    logic [BW-1:0] pix_byte;
    logic [WORD_W-1:0] word;

    vcap_timing_decoder u_dec (
        .clk(clk), .rst(rst), .byte_i(vid_i), .vbi_en_i(vbi_en_i),
        .pix_valid_o(pix_valid), .pix_byte_o(pix_byte), .code_hit_o(code_hit),
        .field_o(field_o), .vblank_o(vblank_o), .eol_o(eol_o)
    );

    vcap_word_packer #(.LANES(LANES), .BYTE_W(BW)) u_pack (
        .clk(clk), .rst(rst), .pix_valid_i(pix_valid), .pix_byte_i(pix_byte),
        .restart_i(code_hit), .push_o(push), .word_o(word)
    );

    vcap_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push_i(push), .data_i(word), .pop_i(rd_en_i),
        .data_o(rd_data_o), .valid_o(rd_valid_o), .ovf_clr_i(ovf_clr_i), .ovf_o(ovf_o)
    );
endmodule

// File: tb/vcap_top_test.sv
`timescale 1ns/1ps
module vcap_top_test;
    logic clk = 0;
    logic rst = 1;
    logic [7:0] vid = 8'h80;
    logic vbi_en = 0, rd_en = 0, ovf_clr = 0;
    logic [31:0] rd_data;
    logic rd_valid, field, vblank, eol, ovf;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    vcap_top uut (
        .clk(clk), .rst(rst), .vid_i(vid), .vbi_en_i(vbi_en), .rd_en_i(rd_en),
        .ovf_clr_i(ovf_clr), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
        .field_o(field), .vblank_o(vblank), .eol_o(eol), .ovf_o(ovf)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pix(input int line, input int i);
        return 8'(16 + ((line * 5 + i) % 200));
    endfunction

    function automatic logic [31:0] word_of(input int line, input int w);
        return {pix(line, 4*w+3), pix(line, 4*w+2), pix(line, 4*w+1), pix(line, 4*w)};
    endfunction

    // status byte: 1 F V H P3 P2 P1 P0
    function automatic logic [7:0] code(input bit f, input bit v, input bit h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        vid = b;
    endtask

    task automatic drain(input int line, input int nw);
        int got = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (rd_valid) begin
                check(rd_data == word_of(line, got), "R4 R5 R8 R10 word", rd_data, word_of(line, got));
                got++;
                rd_en = 1;
            end else begin
                rd_en = 0;
                break;
            end
        end
        rd_en = 0;
        check(got == nw, "R3 R5 R7 R8 word count", 32'(got), 32'(nw));
    endtask

    task automatic send_line(input bit f, input bit v, input int n, input int line);
        put(8'h80); put(8'h10); put(8'h80); put(8'h10);
        put(8'hFF); put(8'h00); put(8'h00); put(code(f, v, 1'b0));
        for (int i = 0; i < n; i++) begin
            put(pix(line, i));
            if (i == 0) check({field, vblank} == {f, v}, "R2 flags after start code", {30'd0, field, vblank}, {30'd0, f, v});
        end
        put(8'hFF); put(8'h00); put(8'h00); put(code(f, v, 1'b1));
        put(8'h80);
        check(eol == 1'b1, "R6 end pulse", 32'(eol), 32'd1);
        check({field, vblank} == {f, v}, "R2 flags after end code", {30'd0, field, vblank}, {30'd0, f, v});
        put(8'h10);
        check(eol == 1'b0, "R6 pulse width", 32'(eol), 32'd0);
        put(8'h80); put(8'h10); put(8'h80);
    endtask

    initial begin
        int line = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(rd_valid == 0, "R1 valid", 32'(rd_valid), 0);
        check(field == 0 && vblank == 0, "R1 flags", {30'd0, field, vblank}, 0);
        check(eol == 0, "R1 eol", 32'(eol), 0);
        check(ovf == 0, "R1 ovf", 32'(ovf), 0);

        // sweep over mode, F, V and line length
        for (int m = 0; m < 2; m++)
            for (int f = 0; f < 2; f++)
                for (int v = 0; v < 2; v++)
                    for (int n = 0; n < 14; n++) begin
                        vbi_en = m[0];
                        send_line(f[0], v[0], n, line);
                        drain(line, (v == 0 || m == 1) ? n / 4 : 0);   // R7
                        line++;
                    end
        vbi_en = 0;
        check(ovf == 0, "R9 no spurious overflow", 32'(ovf), 0);

        // R4 latency: fourth byte sampled at edge k, word visible after k+3
        line = 500;
        put(8'h80); put(8'hFF); put(8'h00); put(8'h00); put(code(1'b0, 1'b0, 1'b0));
        for (int i = 0; i < 4; i++) put(pix(line, i));
        put(pix(line, 4)); check(rd_valid == 0, "R4 not before k+3 (k)", 32'(rd_valid), 0);
        put(pix(line, 5)); check(rd_valid == 0, "R4 not before k+3 (k+1)", 32'(rd_valid), 0);
        put(pix(line, 6)); check(rd_valid == 0, "R4 not before k+3 (k+2)", 32'(rd_valid), 0);
        put(pix(line, 7)); check(rd_valid == 1, "R4 visible after k+3", 32'(rd_valid), 1);
        check(rd_data == word_of(line, 0), "R4 lane order", rd_data, word_of(line, 0));
        put(8'hFF); put(8'h00); put(8'h00); put(code(1'b0, 1'b0, 1'b1));
        put(8'h80); put(8'h10); put(8'h80); put(8'h10);
        drain(line, 2);

        // R9 overflow: 18 words, no reads
        line = 600;
        send_line(1'b0, 1'b0, 72, line);
        check(ovf == 1, "R9 overflow set", 32'(ovf), 1);
        repeat (5) put(8'h80);
        check(ovf == 1, "R9 overflow sticky", 32'(ovf), 1);
        drain(line, 16);
        @(negedge clk); ovf_clr = 1;
        @(negedge clk); ovf_clr = 0;
        check(ovf == 0, "R9 overflow cleared", 32'(ovf), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule